// File: doc/BRIEF.md
# Tagged Return Address Predictor Stack

This block predicts the targets of return instructions. Each call pushes its return address and each return pops the most recent one. The predicted address appears with a valid flag on the clock edge after the return strobe. Every entry records whether host or guest code pushed it. A return in one context never takes an entry that the other context pushed, so host and guest entries can share the stack safely.

How many entries the stack can hold depends on the current context. Host code always gets the extended capacity. Guest code gets the legacy capacity unless its control word grants the larger size. Two events empty the whole stack:
- a write to the page-table base, which marks a context switch;
- a guest entry whose control word carries the flush request.

The tag separates host from guest only. Two guests cannot tell each other's entries apart.

Top module: `ret_addr_stack`

## Requirements
- R1: After reset, pred_valid_o and pred_addr_o are 0, and a return gives pred_valid_o=0.
- R2: A return whose top entry was pushed in the current context raises pred_valid_o in the next cycle, and pred_addr_o then holds the address of the most recent unconsumed call of that context (last in, first out). pred_valid_o is 0 in any cycle that does not follow a return.
- R3: A return on an empty stack, or on a stack whose top entry carries the other context's tag (guest_i=1 guest, 0 host), gives pred_valid_o=0 and leaves the stack unchanged.
- R4: In host context the stack holds 64 entries. A call on a full stack overwrites the oldest entry.
- R5: In guest context with gctl_i bit 0 clear, the stack holds 32 entries.
- R6: In guest context with gctl_i bit 0 set, the stack holds 64 entries.
- R7: guest_entry_i with gctl_i bit 1 set empties the stack. guest_entry_i with gctl_i bit 1 clear leaves it intact.
- R8: ptbase_wr_i empties the stack.
- R9: A call or return in the same cycle as a flush takes effect after the flush. The return misses, and the call's entry survives.
- R10: When the active capacity falls from 64 to 32, only the 32 most recent entries remain.
- R11: A call and a return in the same cycle pop first and then push.
- R12: Entries pushed by one guest can be consumed by another guest that is entered without a flush request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| call_i | input | 1 | Call strobe: push call_addr_i |
| ret_i | input | 1 | Return strobe: pop a prediction |
| call_addr_i | input | ADDR_W | Return address to push |
| guest_i | input | 1 | Current context: 1 guest, 0 host |
| ptbase_wr_i | input | 1 | Page-table base write strobe |
| guest_entry_i | input | 1 | Guest entry strobe |
| gctl_i | input | 2 | Guest control: bit 0 allow larger stack, bit 1 flush on entry |
| pred_addr_o | output | ADDR_W | Predicted return address |
| pred_valid_o | output | 1 | Prediction valid |

## Verification
The assertions treat every strobe as a per-cycle level. They assume that gctl_i is meaningful in every cycle, because the capacity clamp and the entry flush read it whatever the context. They also assume that the context may change in any cycle with no handshake. The stimulus keeps to these assumptions. It drives all inputs as full-cycle levels that change only at the falling edge. It holds a context for many cycles before switching, and it sweeps the control word over all four values in both contexts.

// File: rtl/ras_pkg.sv
package ras_pkg;
  typedef enum logic {
    CTX_HOST  = 1'b0,
    CTX_GUEST = 1'b1
  } ctx_e;

  // control word layout: bit 1 flush request, bit 0 allow larger stack
  typedef struct packed {
    logic flush_req;
    logic allow_big;
  } gctl_t;
endpackage

// File: rtl/ras_depth_sel.sv
module ras_depth_sel
  import ras_pkg::*;
#(
  parameter int EXT_DEPTH = 64,
  parameter int LEG_DEPTH = 32,
  parameter int CNT_W     = $clog2(EXT_DEPTH + 1)
) (
  input  ctx_e             ctx,
  input  logic             allow_big,
  output logic [CNT_W-1:0] depth
);
  localparam logic [CNT_W-1:0] EXT_CAP = CNT_W'(EXT_DEPTH);
  localparam logic [CNT_W-1:0] LEG_CAP = CNT_W'(LEG_DEPTH);

  generate
    if (LEG_DEPTH >= EXT_DEPTH) begin : g_flat
      assign depth = EXT_CAP;
    end else begin : g_split
      always_comb begin
        if (ctx == CTX_GUEST && !allow_big) depth = LEG_CAP;
        else                                depth = EXT_CAP;
      end
    end
  endgenerate
endmodule

// File: rtl/ras_ptr_ctrl.sv
module ras_ptr_ctrl
  import ras_pkg::*;
#(
  parameter int EXT_DEPTH = 64,
  parameter int PTR_W     = $clog2(EXT_DEPTH),
  parameter int CNT_W     = $clog2(EXT_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             push,
  input  logic             pop,
  input  ctx_e             ctx,
  input  logic [CNT_W-1:0] depth,
  input  logic             top_tag,
  output logic             hit,
  output logic [PTR_W-1:0] rd_idx,
  output logic             wr_en,
  output logic [PTR_W-1:0] wr_idx,
  output logic [CNT_W-1:0] cnt_q
);
  logic [PTR_W-1:0] tos_q, tos_pop, tos_nxt;
  logic [CNT_W-1:0] cnt_clamp, cnt_pop, cnt_nxt;

  always_comb begin
    if (flush)             cnt_clamp = '0;
    else if (cnt_q > depth) cnt_clamp = depth;
    else                   cnt_clamp = cnt_q;

    hit     = pop && (cnt_clamp != '0) && (top_tag == logic'(ctx));
    cnt_pop = cnt_clamp - CNT_W'(hit);
    tos_pop = tos_q - PTR_W'(hit);

    wr_en  = push;
    wr_idx = tos_pop + PTR_W'(1);

    if (push) begin
      tos_nxt = wr_idx;
      cnt_nxt = (cnt_pop >= depth) ? depth : cnt_pop + CNT_W'(1);
    end else begin
      tos_nxt = tos_pop;
      cnt_nxt = cnt_pop;
    end
  end

  assign rd_idx = tos_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tos_q <= '0;
      cnt_q <= '0;
    end else begin
      tos_q <= tos_nxt;
      cnt_q <= cnt_nxt;
    end
  end
endmodule

// File: rtl/ras_tagfile.sv
module ras_tagfile #(
  parameter int EXT_DEPTH = 64,
  parameter int PTR_W     = $clog2(EXT_DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [PTR_W-1:0] wr_idx,
  input  logic             wr_tag,
  input  logic [PTR_W-1:0] rd_idx,
  output logic             rd_tag
);
  logic [EXT_DEPTH-1:0] tag_q;

  generate
    for (genvar i = 0; i < EXT_DEPTH; i++) begin : g_tag
      always_ff @(posedge clk) begin
        if (rst)                                   tag_q[i] <= 1'b0;
        else if (wr_en && wr_idx == PTR_W'(i))     tag_q[i] <= wr_tag;
      end
    end
  endgenerate

  assign rd_tag = tag_q[rd_idx];
endmodule

// File: rtl/ras_addr_ram.sv
module ras_addr_ram #(
  parameter int ADDR_W    = 32,
  parameter int EXT_DEPTH = 64,
  parameter int PTR_W     = $clog2(EXT_DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [PTR_W-1:0]  wa,
  input  logic [ADDR_W-1:0] wd,
  input  logic              re,
  input  logic [PTR_W-1:0]  ra,
  output logic [ADDR_W-1:0] rd_q
);
  logic [ADDR_W-1:0] mem [EXT_DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
  end

  // read-first: a same-address write in this cycle is not seen
  always_ff @(posedge clk) begin
    if (rst)     rd_q <= '0;
    else if (re) rd_q <= mem[ra];
  end
endmodule

// File: rtl/ret_addr_stack.sv
module ret_addr_stack
  import ras_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int EXT_DEPTH = 64,
  parameter int LEG_DEPTH = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              call_i,
  input  logic              ret_i,
  input  logic [ADDR_W-1:0] call_addr_i,
  input  logic              guest_i,
  input  logic              ptbase_wr_i,
  input  logic              guest_entry_i,
  input  logic [1:0]        gctl_i,
  output logic [ADDR_W-1:0] pred_addr_o,
  output logic              pred_valid_o
);
  localparam int PTR_W = $clog2(EXT_DEPTH);
  localparam int CNT_W = $clog2(EXT_DEPTH + 1);

  ctx_e             ctx;
  gctl_t            gctl;
  logic             flush;
  logic [CNT_W-1:0] depth;
  logic [CNT_W-1:0] cnt_q;
  logic             top_tag;
  logic             hit;
  logic [PTR_W-1:0] rd_idx, wr_idx;
  logic             wr_en;
  logic             valid_q;

  assign ctx   = ctx_e'(guest_i);
  assign gctl  = gctl_t'(gctl_i);
  assign flush = ptbase_wr_i || (guest_entry_i && gctl.flush_req);

  ras_depth_sel #(
    .EXT_DEPTH(EXT_DEPTH), .LEG_DEPTH(LEG_DEPTH), .CNT_W(CNT_W)
  ) u_depth (
    .ctx(ctx), .allow_big(gctl.allow_big), .depth(depth)
  );

  ras_ptr_ctrl #(
    .EXT_DEPTH(EXT_DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .flush(flush), .push(call_i), .pop(ret_i),
    .ctx(ctx), .depth(depth), .top_tag(top_tag), .hit(hit),
    .rd_idx(rd_idx), .wr_en(wr_en), .wr_idx(wr_idx), .cnt_q(cnt_q)
  );

  ras_tagfile #(
    .EXT_DEPTH(EXT_DEPTH), .PTR_W(PTR_W)
  ) u_tags (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_tag(logic'(ctx)), .rd_idx(rd_idx), .rd_tag(top_tag)
  );

  ras_addr_ram #(
    .ADDR_W(ADDR_W), .EXT_DEPTH(EXT_DEPTH), .PTR_W(PTR_W)
  ) u_ram (
    .clk(clk), .rst(rst), .we(wr_en), .wa(wr_idx), .wd(call_addr_i),
    .re(ret_i), .ra(rd_idx), .rd_q(pred_addr_o)
  );

  always_ff @(posedge clk) begin
    if (rst) valid_q <= 1'b0;
    else     valid_q <= hit;
  end

  assign pred_valid_o = valid_q;
endmodule

// File: rtl/ret_addr_stack_chk.sv
module ret_addr_stack_chk #(
  parameter int EXT_DEPTH = 64,
  parameter int LEG_DEPTH = 32,
  parameter int CNT_W     = $clog2(EXT_DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             ret_i,
  input logic             guest_i,
  input logic             ptbase_wr_i,
  input logic             guest_entry_i,
  input logic [1:0]       gctl_i,
  input logic             pred_valid_o,
  input logic [CNT_W-1:0] cnt_q,
  input logic             top_tag
);
  AST_IDLE_NO_PRED: assert property (@(posedge clk) disable iff (rst)
    !ret_i |=> !pred_valid_o); // R2

  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (rst)
    (ret_i && cnt_q == '0) |=> !pred_valid_o); // R3

  AST_TAG_MISMATCH: assert property (@(posedge clk) disable iff (rst)
    (ret_i && top_tag != guest_i) |=> !pred_valid_o); // R3

  AST_CNT_MAX: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(EXT_DEPTH)); // R4

  AST_GUEST_LEGACY: assert property (@(posedge clk) disable iff (rst)
    (guest_i && !gctl_i[0]) |=> cnt_q <= CNT_W'(LEG_DEPTH)); // R5

  AST_ENTRY_FLUSH: assert property (@(posedge clk) disable iff (rst)
    (guest_entry_i && gctl_i[1] && ret_i) |=> !pred_valid_o); // R7

  AST_PT_FLUSH: assert property (@(posedge clk) disable iff (rst)
    (ptbase_wr_i && ret_i) |=> !pred_valid_o); // R8
endmodule

bind ret_addr_stack ret_addr_stack_chk #(
  .EXT_DEPTH(EXT_DEPTH), .LEG_DEPTH(LEG_DEPTH)
) u_chk (
  .clk(clk), .rst(rst), .ret_i(ret_i), .guest_i(guest_i),
  .ptbase_wr_i(ptbase_wr_i), .guest_entry_i(guest_entry_i), .gctl_i(gctl_i),
  .pred_valid_o(pred_valid_o), .cnt_q(cnt_q), .top_tag(top_tag)
);

// File: tb/ret_addr_stack_tb.sv
module ret_addr_stack_tb;
  localparam int AW = 32;
  localparam int XD = 64;
  localparam int LD = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          call_i = 0, ret_i = 0, guest_i = 0;
  logic          ptbase_wr_i = 0, guest_entry_i = 0;
  logic [AW-1:0] call_addr_i = '0;
  logic [1:0]    gctl_i = '0;
  logic [AW-1:0] pred_addr_o;
  logic          pred_valid_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // ordered model: index 0 is the most recent entry
  logic [AW-1:0] m_addr [XD];
  logic          m_tag  [XD];
  int            m_len = 0;

  always #4 clk = ~clk;

  ret_addr_stack #(.ADDR_W(AW), .EXT_DEPTH(XD), .LEG_DEPTH(LD)) u_dut (
    .clk(clk), .rst(rst), .call_i(call_i), .ret_i(ret_i),
    .call_addr_i(call_addr_i), .guest_i(guest_i), .ptbase_wr_i(ptbase_wr_i),
    .guest_entry_i(guest_entry_i), .gctl_i(gctl_i),
    .pred_addr_o(pred_addr_o), .pred_valid_o(pred_valid_o)
  );

  task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic c, input logic r, input logic [AW-1:0] a,
                     input logic g, input logic pt, input logic ge,
                     input logic [1:0] ctl, input string req);
    int d;
    logic ev;
    logic [AW-1:0] ea;
    call_i = c; ret_i = r; call_addr_i = a; guest_i = g;
    ptbase_wr_i = pt; guest_entry_i = ge; gctl_i = ctl;
    @(posedge clk);
    d  = (g && !ctl[0]) ? LD : XD;
    ev = 1'b0; ea = '0;
    if (pt || (ge && ctl[1])) m_len = 0;
    else if (m_len > d)       m_len = d;
    if (r && m_len > 0 && m_tag[0] == g) begin
      ev = 1'b1; ea = m_addr[0];
      for (int i = 0; i < XD - 1; i++) begin
        m_addr[i] = m_addr[i+1]; m_tag[i] = m_tag[i+1];
      end
      m_len--;
    end
    if (c) begin
      for (int i = XD - 1; i > 0; i--) begin
        m_addr[i] = m_addr[i-1]; m_tag[i] = m_tag[i-1];
      end
      m_addr[0] = a; m_tag[0] = g;
      if (m_len < d) m_len++;
    end
    @(negedge clk);
    check({req, " valid"}, AW'(pred_valid_o), AW'(ev));
    if (ev) check({req, " addr"}, pred_addr_o, ea);
  endtask

  task automatic idle(input logic g, input logic [1:0] ctl, input string req);
    cyc(0, 0, '0, g, 0, 0, ctl, req);
  endtask

  task automatic pushes(input int n, input logic [AW-1:0] base, input logic g,
                        input logic [1:0] ctl, input string req);
    for (int i = 0; i < n; i++) cyc(1, 0, base + AW'(i), g, 0, 0, ctl, req);
  endtask

  task automatic pops(input int n, input logic g, input logic [1:0] ctl, input string req);
    for (int i = 0; i < n; i++) cyc(0, 1, '0, g, 0, 0, ctl, req);
  endtask

  task automatic drain();
    cyc(0, 0, '0, 0, 1, 0, 2'b00, "R8");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 valid", AW'(pred_valid_o), '0);
    check("R1 addr", pred_addr_o, '0);
    pops(1, 0, 2'b00, "R1");

    // R2 LIFO in host, then in guest
    pushes(5, 32'h100, 0, 2'b00, "R2");
    pops(6, 0, 2'b00, "R2");
    pushes(4, 32'h200, 1, 2'b00, "R2");
    pops(5, 1, 2'b00, "R2");

    // R3 tag separation: guest cannot consume host entries
    pushes(3, 32'h300, 0, 2'b00, "R3");
    pops(2, 1, 2'b00, "R3");
    pushes(2, 32'h380, 1, 2'b00, "R3");
    pops(3, 1, 2'b00, "R3");
    pops(4, 0, 2'b00, "R3");

    // R4 host capacity 64 with wrap overwrite
    pushes(70, 32'h1000, 0, 2'b00, "R4");
    pops(66, 0, 2'b00, "R4");

    // R5 guest legacy capacity 32
    pushes(40, 32'h2000, 1, 2'b00, "R5");
    pops(34, 1, 2'b00, "R5");

    // R6 guest with allow bit gets 64
    pushes(70, 32'h3000, 1, 2'b01, "R6");
    pops(66, 1, 2'b01, "R6");

    // R7 entry flush with request, keep without
    pushes(4, 32'h4000, 1, 2'b00, "R7");
    cyc(0, 0, '0, 1, 0, 1, 2'b00, "R7");
    pops(1, 1, 2'b00, "R7");
    cyc(0, 0, '0, 1, 0, 1, 2'b10, "R7");
    pops(2, 1, 2'b10, "R7");

    // R8 page-table base write flush
    pushes(6, 32'h5000, 0, 2'b00, "R8");
    cyc(0, 0, '0, 0, 1, 0, 2'b00, "R8");
    pops(2, 0, 2'b00, "R8");

    // R9 flush in the same cycle as call and return
    pushes(3, 32'h6000, 0, 2'b00, "R9");
    cyc(1, 1, 32'h6100, 0, 1, 0, 2'b00, "R9");
    pops(2, 0, 2'b00, "R9");
    pushes(3, 32'h6200, 1, 2'b00, "R9");
    cyc(1, 1, 32'h6300, 1, 0, 1, 2'b10, "R9");
    pops(2, 1, 2'b00, "R9");

    // R10 depth drop keeps only the 32 most recent
    pushes(50, 32'h7000, 0, 2'b00, "R10");
    idle(1, 2'b00, "R10");
    pops(34, 0, 2'b00, "R10");
    pushes(45, 32'h7800, 1, 2'b01, "R10");
    idle(1, 2'b00, "R10");
    pops(34, 1, 2'b01, "R10");

    // R11 call and return together: pop then push
    pushes(2, 32'h8000, 0, 2'b00, "R11");
    cyc(1, 1, 32'h8100, 0, 0, 0, 2'b00, "R11");
    cyc(1, 1, 32'h8200, 0, 0, 0, 2'b00, "R11");
    pops(3, 0, 2'b00, "R11");
    cyc(1, 1, 32'h8300, 0, 0, 0, 2'b00, "R11");
    pops(2, 0, 2'b00, "R11");

    // R12 a second guest entered without flush sees first guest entries
    pushes(3, 32'h9000, 1, 2'b00, "R12");
    idle(0, 2'b00, "R12");
    cyc(0, 0, '0, 1, 0, 1, 2'b01, "R12");
    pops(4, 1, 2'b01, "R12");

    // sweep: every control word in both contexts, mixed traffic
    drain();
    for (int k = 0; k < 8; k++) begin
      logic g;
      logic [1:0] ctl;
      g = k[0]; ctl = k[2:1];
      for (int j = 0; j < 400; j++) begin
        int rv;
        rv = int'($urandom_range(0, 99));
        cyc(rv < 55, (rv >= 40 && rv < 90), 32'hA000_0000 + AW'(k * 1000 + j),
            g, rv == 97, rv == 98, ctl, "R2");
      end
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule